// File: doc/BRIEF.md
# Interrupt Request Pending Unit

This unit gathers interrupt requests from a small set of external push-button sources and turns them into a single request line toward a simple microcoded CPU. Each source is brought into the clock domain by a short flop chain and reduced to a one-cycle pulse on its rising edge. That pulse latches a bit in a pending register, and each bit position belongs to one source. Button bit 0 is source A, bit 1 is B, bit 2 is C and bit 3 is D.

The CPU sees the pending register as a read-only status nibble on `pend_o`, which its address decoder maps into memory space. Service firmware polls this nibble to learn which source fired. It then writes a mask to clear the bits it has handled. An enable flag gates the request. The CPU's interrupt-entry sequence pulses `ien_clr_i`, and its return sequence pulses `ien_set_i`. The CPU samples `irq_o` only at the end of each instruction, so a request that arrives in the middle of an instruction waits in the register.

Top module: `irq_pend_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the pending nibble, the enable flag and the request line all become 0.
- R2: A rising level on `btn_i[i]` sets `pend_o[i]`. The bit is visible after the third rising clock edge that follows the input change, and not after the second.
- R3: A button that stays high sets its bit only once. A falling level never sets a bit. A button held high does not set its bit again after that bit has been cleared.
- R4: A cycle with `pend_wr_i` high clears each pending bit where `pend_wdata_i` holds a 1 and leaves every other bit unchanged. Without a write, no pending bit ever drops.
- R5: If a new edge on source i and a clear of bit i fall in the same cycle, bit i ends up set.
- R6: `irq_o` is 1 exactly when `ien_o` is 1 and at least one pending bit is 1, and it is updated on the same edge as both of them.
- R7: A cycle with `ien_set_i` raises `ien_o` on the next edge. A cycle with `ien_clr_i` lowers it on the next edge. When both pulses come together, the clear wins.
- R8: Pending bits latch and stay readable on `pend_o` while the enable flag is 0.
- R9: Edges on several sources that arrive together set all of their bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 4 | Asynchronous request levels, one per source |
| pend_wr_i | input | 1 | Write strobe for the pending register's address |
| pend_wdata_i | input | 4 | Write data; a 1 clears the matching pending bit |
| ien_set_i | input | 1 | Enable pulse from the return-from-interrupt sequence |
| ien_clr_i | input | 1 | Disable pulse from interrupt entry |
| pend_o | output | 4 | Pending nibble that firmware polls |
| ien_o | output | 1 | Enable flag |
| irq_o | output | 1 | Request line to the CPU |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an edge that sets a pending bit and a firmware write that clears the same bit. The bench raises a button, counts two edges so that the write lands in the cycle where the detected edge is active, and then expects that bit set while the other bits it wrote were cleared. The second pair is the enable-set and enable-clear pulses. The bench drives both in one cycle and expects the flag low and no request.

// File: rtl/irq_pkg.sv
package irq_pkg;

    parameter int unsigned NUM_SRC = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // firmware clear request, one mask bit per source
    typedef struct packed {
        logic     wr;
        src_vec_t mask;
    } clr_req_t;

    // enable flag commands from the CPU sequencer
    typedef struct packed {
        logic set;
        logic clr;
    } ien_cmd_t;

    // new edges win over a clear of the same bit
    function automatic src_vec_t pend_next(input src_vec_t cur,
                                           input src_vec_t edges,
                                           input clr_req_t req);
        src_vec_t kept;
        kept = req.wr ? (cur & ~req.mask) : cur;
        return kept | edges;
    endfunction

    // clear has priority over set
    function automatic logic ien_next(input logic cur, input ien_cmd_t cmd);
        if (cmd.clr)      return 1'b0;
        else if (cmd.set) return 1'b1;
        else              return cur;
    endfunction

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[LAST];
        end
    end

    assign rise = chain[LAST] & ~prev;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t edges,
    input  clr_req_t req,
    output src_vec_t pend_q,
    output src_vec_t pend_d
);
    always_comb pend_d = pend_next(pend_q, edges, req);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end
endmodule

// File: rtl/irq_ien_ctrl.sv
module irq_ien_ctrl
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ien_cmd_t cmd,
    output logic     ien_q,
    output logic     ien_d
);
    always_comb ien_d = ien_next(ien_q, cmd);

    always_ff @(posedge clk) begin
        if (rst) ien_q <= 1'b0;
        else     ien_q <= ien_d;
    end
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
    import irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] btn_i,
    input  logic       pend_wr_i,
    input  logic [3:0] pend_wdata_i,
    input  logic       ien_set_i,
    input  logic       ien_clr_i,
    output logic [3:0] pend_o,
    output logic       ien_o,
    output logic       irq_o
);
    src_vec_t edges;
    src_vec_t pend_q, pend_d;
    clr_req_t req;
    ien_cmd_t cmd;
    logic     ien_q, ien_d;
    logic     irq_q;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            irq_sync_edge #(.STAGES(SYNC_STAGES)) u_se (
                .clk  (clk),
                .rst  (rst),
                .din  (btn_i[i]),
                .rise (edges[i])
            );
        end
    endgenerate

    always_comb begin
        req.wr   = pend_wr_i;
        req.mask = pend_wdata_i;
        cmd.set  = ien_set_i;
        cmd.clr  = ien_clr_i;
    end

    irq_pend_reg u_pend (
        .clk    (clk),
        .rst    (rst),
        .edges  (edges),
        .req    (req),
        .pend_q (pend_q),
        .pend_d (pend_d)
    );

    irq_ien_ctrl u_ien (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .ien_q (ien_q),
        .ien_d (ien_d)
    );

    // request flag tracks the next state of both sources
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= ien_d & (|pend_d);
    end

    assign pend_o = pend_q;
    assign ien_o  = ien_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk (
    input logic       clk,
    input logic       rst,
    input logic       pend_wr_i,
    input logic       ien_set_i,
    input logic       ien_clr_i,
    input logic [3:0] pend_o,
    input logic       ien_o,
    input logic       irq_o
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: state is cleared after a reset edge
    always @(negedge clk) begin
        if (rst_q === 1'b1)
            p_reset_state_r1: assert (pend_o == 4'd0 && !ien_o && !irq_o);
    end

    // R6: request only when enabled and something pending
    p_irq_needs_ien_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ien_o && (|pend_o)));

    // R6: enabled and pending implies request
    p_irq_follows_r6: assert property (@(posedge clk) disable iff (rst)
        (ien_o && (|pend_o)) |-> irq_o);

    // R7: disable pulse always wins
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        ien_clr_i |=> !ien_o);

    // R7: enable pulse alone raises the flag
    p_set_ien_r7: assert property (@(posedge clk) disable iff (rst)
        (ien_set_i && !ien_clr_i) |=> ien_o);

    // R4: without a write no pending bit drops
    p_no_drop_r4: assert property (@(posedge clk) disable iff (rst)
        !pend_wr_i |=> (($past(pend_o) & ~pend_o) == 4'd0));
endmodule

bind irq_pend_unit irq_pend_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pend_wr_i (pend_wr_i),
    .ien_set_i (ien_set_i),
    .ien_clr_i (ien_clr_i),
    .pend_o    (pend_o),
    .ien_o     (ien_o),
    .irq_o     (irq_o)
);

// File: tb/sim_irq_pend_unit.sv
module sim_irq_pend_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] btn = '0;
    logic       wr = 1'b0;
    logic [3:0] wdata = '0;
    logic       iset = 1'b0;
    logic       iclr = 1'b0;
    logic [3:0] pend;
    logic       ien, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;  // 125 MHz

    irq_pend_unit u0 (
        .clk(clk), .rst(rst), .btn_i(btn), .pend_wr_i(wr),
        .pend_wdata_i(wdata), .ien_set_i(iset), .ien_clr_i(iclr),
        .pend_o(pend), .ien_o(ien), .irq_o(irq)
    );

    typedef struct packed {
        logic [3:0] btn;
        logic       wr;
        logic [3:0] wdata;
        logic       iset;
        logic       iclr;
        logic [3:0] e_pend;
        logic       e_ien;
        logic       e_irq;
    } step_t;

    localparam int NSTEP = 8;
    localparam step_t VEC [NSTEP] = '{
        '{4'b0001, 1'b0, 4'b0000, 1'b1, 1'b0, 4'b0001, 1'b1, 1'b1}, // R2 R6 R7
        '{4'b0001, 1'b0, 4'b0000, 1'b0, 1'b1, 4'b0001, 1'b0, 1'b0}, // R7 R6
        '{4'b0000, 1'b1, 4'b0001, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0}, // R4 R3 fall
        '{4'b0110, 1'b0, 4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0}, // R9 R8
        '{4'b0110, 1'b1, 4'b0010, 1'b0, 1'b0, 4'b0100, 1'b0, 1'b0}, // R3 held, R4
        '{4'b1110, 1'b0, 4'b0000, 1'b1, 1'b1, 4'b1100, 1'b0, 1'b0}, // R7 both
        '{4'b0000, 1'b0, 4'b0000, 1'b1, 1'b0, 4'b1100, 1'b1, 1'b1}, // R3 fall, R6
        '{4'b0000, 1'b1, 4'b1111, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0}  // R4 R6
    };

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual pend/ien/irq=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {pend, ien, irq}, 6'b0);
        rst = 1'b0;

        for (int s = 0; s < NSTEP; s++) begin
            @(negedge clk);
            btn = VEC[s].btn; wr = VEC[s].wr; wdata = VEC[s].wdata;
            iset = VEC[s].iset; iclr = VEC[s].iclr;
            @(posedge clk);
            @(negedge clk);
            wr = 1'b0; wdata = '0; iset = 1'b0; iclr = 1'b0;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check($sformatf("table R2 R3 R4 R6 R7 R8 R9 step %0d", s),
                  {pend, ien, irq}, {VEC[s].e_pend, VEC[s].e_ien, VEC[s].e_irq});
        end

        // R2: latency, pend is clear and ien is 1 here
        @(negedge clk);
        btn = 4'b0001;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R2 not yet after two edges", {pend, ien, irq}, 6'b000010);
        @(posedge clk);
        @(negedge clk);
        check("R2 set after third edge", {pend, ien, irq}, 6'b000111);

        // R5: set and clear of the same bit together; bit0 set, others written cleared
        btn = 4'b0000;
        wr = 1'b1; wdata = 4'b0001;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; wdata = '0;
        btn = 4'b1000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        btn = 4'b1001;  // bit3 held, bit0 rises
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        wr = 1'b1; wdata = 4'b1111;  // lands in the edge-active cycle
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; wdata = '0;
        check("R5 set beats clear", {pend, ien, irq}, 6'b000111);

        // R1: reset in mid-run
        rst = 1'b1;
        btn = 4'b0000;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset", {pend, ien, irq}, 6'b0);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 stays idle after reset", {pend, ien, irq}, 6'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule